// File: doc/BRIEF.md
# Burst Column Order Generator

This block sits behind the command decoder of a double-data-rate memory device model or controller. When a read or write command is accepted it latches the starting column bits, the burst-length mode, the burst-type mode, the per-command chop select and the direction. It then steps through eight beat slots, one per clock, and for each slot reports the column offset inside the eight-column block. It also reports whether the slot carries data, whether the device drives the data bus in that slot, and where the internal write operation starts, which write-recovery timing counts from.

The burst-length mode is a 2-bit code. 00 selects a fixed burst of eight. 10 selects a fixed chop to four. 01 lets each command choose, and 11 is reserved. A reserved code is treated as a burst of eight and flags an error. In the per-command mode the chop select is active low: 0 selects chop-4 and 1 selects a full burst. The burst-type bit is 0 for sequential order and 1 for interleaved order. A new command can be accepted while idle, or in the last beat slot to run back to back. A command that arrives in any other slot of a burst is refused and has no effect.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and whenever no burst is running, beatValid, colIdx, dataValid, driveEn, wrRecStart and modeErr are all 0.
- R2: On a sequential read (typeInterleave=0), beat i reports column {CA[2] xor i[2], (CA[1:0] + i[1:0]) mod 4}. For example, start 5 gives 5,6,7,4,1,2,3,0.
- R3: On an interleaved read (typeInterleave=1), beat i reports column CA xor i. For example, start 6 gives 6,7,4,5,2,3,0,1.
- R4: On a chopped read, beats 0 to 3 follow the order selected by R2 or R3 with dataValid=1 and driveEn=1. Beats 4 to 7 have dataValid=0, driveEn=0 and colIdx=0. On an unchopped read, all eight beats have dataValid=1 and driveEn=1.
- R5: On a chopped write, beat i (0 to 3) reports {CA[2], i[1:0]} for both burst types, with CA[1:0] ignored. Beats 4 to 7 have dataValid=0 and colIdx=0. driveEn is 0 for every write beat.
- R6: On an unchopped write, beat i reports column i for both burst types and any CA, with dataValid=1.
- R7: Burst-length code 00 never chops and code 10 always chops. Under code 01, cmdChopN=0 chops and cmdChopN=1 gives eight beats.
- R8: Burst-length code 11 runs an unchopped burst, and modeErr is 1 for each of its eight beats.
- R9: wrRecStart pulses once per write burst. It pulses at beat 5 when the chop came from code 10, and at beat 7 otherwise, including a chop selected through code 01. It never pulses for reads.
- R10: Every burst occupies exactly eight consecutive beat slots. A command presented in beat 7 starts its beat 0 in the following cycle.
- R11: A command presented during beats 0 to 6 raises busyReject in the same cycle and does not alter the running burst.
- R12: Mode, start-column and chop inputs are sampled only when a command is accepted. Changing them during a burst does not change that burst's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one beat slot per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Read or write command presented |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdChopN | input | 1 | Per-command chop select, active low (used under code 01) |
| startCol | input | 3 | Starting column bits CA[2:0] |
| modeBurstLen | input | 2 | Burst-length code: 00 eight, 01 per command, 10 chop-4, 11 reserved |
| typeInterleave | input | 1 | Burst type: 0 sequential, 1 interleaved |
| beatValid | output | 1 | A burst slot is running |
| colIdx | output | 3 | Column offset for this beat (0 in slots without data) |
| dataValid | output | 1 | This slot carries burst data |
| driveEn | output | 1 | Device drives data and strobe in this slot (reads only) |
| wrRecStart | output | 1 | Internal write start reference for recovery timing |
| busyReject | output | 1 | Command refused because a burst is mid-way |
| modeErr | output | 1 | Running burst was issued under the reserved code |

## Verification
The bench builds the block with its default three-bit column offset, which gives eight-slot bursts, and a two-slot early write start. At this size all eight start columns, all four burst-length codes, both burst types, both directions and both chop select levels can be covered many times over in a few hundred random bursts. Directed passes add back-to-back commands in the last slot, commands refused mid-burst, and mode inputs changed during a burst. Because the window is only eight slots wide, the bench can check every slot of every burst against its own model of the order.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  parameter int COL_W = 3;
  localparam int BURST_SLOTS = 1 << COL_W;
  localparam logic [COL_W-1:0] LAST_BEAT = COL_W'(BURST_SLOTS - 1);

  typedef enum logic [1:0] {
    BL_FIXED8 = 2'b00,
    BL_ONFLY  = 2'b01,
    BL_FIXED4 = 2'b10,
    BL_RSVD   = 2'b11
  } burstLen_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic             active;
    logic [COL_W-1:0] beat;
    logic             isWrite;
    logic             chop;
    logic             fixedChop;
    logic             interleave;
    logic [COL_W-1:0] ca;
  } beatCtl_t;
endpackage

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
  import burst_col_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdWrite,
  input  logic             cmdChopN,
  input  logic [COL_W-1:0] startCol,
  input  logic [1:0]       modeBurstLen,
  input  logic             typeInterleave,
  output beatCtl_t         ctl,
  output logic             busyReject,
  output logic             modeErr
);
  logic lastBeat;
  logic accept;
  logic errQ;
  logic chopSel;
  logic fixedSel;
  burstLen_e blMode;

  assign blMode     = burstLen_e'(modeBurstLen);
  assign lastBeat   = ctl.active && (ctl.beat == LAST_BEAT);
  assign accept     = cmdValid && (!ctl.active || lastBeat);
  assign busyReject = cmdValid && ctl.active && !lastBeat;
  assign modeErr    = ctl.active && errQ;

  always_comb begin
    chopSel  = 1'b0;
    fixedSel = 1'b0;
    unique case (blMode)
      BL_FIXED8: chopSel = 1'b0;
      BL_FIXED4: begin chopSel = 1'b1; fixedSel = 1'b1; end
      BL_ONFLY:  chopSel = !cmdChopN;
      BL_RSVD:   chopSel = 1'b0;
      default:   chopSel = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctl  <= '0;
      errQ <= 1'b0;
    end else if (accept) begin
      ctl.active     <= 1'b1;
      ctl.beat       <= '0;
      ctl.isWrite    <= cmdWrite;
      ctl.chop       <= chopSel;
      ctl.fixedChop  <= fixedSel;
      ctl.interleave <= typeInterleave;
      ctl.ca         <= startCol;
      errQ           <= (blMode == BL_RSVD);
    end else if (ctl.active) begin
      ctl.beat <= ctl.beat + 1'b1;
      if (lastBeat) ctl.active <= 1'b0;
    end
  end

  // R10: slots advance one per cycle without gaps inside a burst
  a_r10_beat_advance: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && ctl.beat != LAST_BEAT) |=> (ctl.active && ctl.beat == $past(ctl.beat) + 1'b1));
  // R11: a refused command leaves the running burst untouched
  a_r11_reject_keeps_burst: assert property (@(posedge clk) disable iff (!rstN)
    busyReject |=> (ctl.active && $stable(ctl.ca) && $stable(ctl.isWrite) && $stable(ctl.chop)));
  // R8: reserved code never chops
  a_r8_rsvd_full: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> (!ctl.chop && !ctl.fixedChop));
  // R9: only fixed chop pulls the write start in
  a_r9_fixed_implies_chop: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && ctl.fixedChop) |-> ctl.chop);
endmodule

// File: rtl/bcg_datapath.sv
module bcg_datapath
  import burst_col_pkg::*;
#(
  parameter int EARLY_SLOTS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  beatCtl_t         ctl,
  output logic [COL_W-1:0] colIdx,
  output logic             dataValid,
  output logic             driveEn,
  output logic             wrRecStart
);
  localparam logic [COL_W-1:0] EARLY_BEAT = COL_W'(BURST_SLOTS - 1 - EARLY_SLOTS);

  logic             upperHalf;
  logic [COL_W-2:0] lowBits;
  logic [COL_W-1:0] rawCol;

  assign upperHalf = ctl.beat[COL_W-1];
  assign lowBits   = ctl.beat[COL_W-2:0];

  always_comb begin
    if (ctl.isWrite) begin
      rawCol = ctl.chop ? {ctl.ca[COL_W-1], lowBits} : ctl.beat;
    end else if (ctl.interleave) begin
      rawCol = ctl.ca ^ ctl.beat;
    end else begin
      rawCol = {ctl.ca[COL_W-1] ^ upperHalf, ctl.ca[COL_W-2:0] + lowBits};
    end
  end

  assign dataValid  = ctl.active && !(ctl.chop && upperHalf);
  assign driveEn    = dataValid && !ctl.isWrite;
  assign colIdx     = dataValid ? rawCol : '0;
  assign wrRecStart = ctl.active && ctl.isWrite &&
                      (ctl.beat == (ctl.fixedChop ? EARLY_BEAT : LAST_BEAT));

  // R1: nothing leaves the block while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.active |-> (!dataValid && !driveEn && !wrRecStart && colIdx == '0));
  // R4: chopped read slots past the first half stay off the bus
  a_r4_chop_tristate: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && !ctl.isWrite && ctl.chop && upperHalf) |-> (!driveEn && !dataValid));
  // R5: the device never drives during a write
  a_r5_write_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && ctl.isWrite) |-> !driveEn);
  // R9: the write reference pulse lasts a single slot
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrRecStart |=> !wrRecStart);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int EARLY_SLOTS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdWrite,
  input  logic             cmdChopN,
  input  logic [COL_W-1:0] startCol,
  input  logic [1:0]       modeBurstLen,
  input  logic             typeInterleave,
  output logic             beatValid,
  output logic [COL_W-1:0] colIdx,
  output logic             dataValid,
  output logic             driveEn,
  output logic             wrRecStart,
  output logic             busyReject,
  output logic             modeErr
);
  beatCtl_t ctl;

  bcg_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cmdValid      (cmdValid),
    .cmdWrite      (cmdWrite),
    .cmdChopN      (cmdChopN),
    .startCol      (startCol),
    .modeBurstLen  (modeBurstLen),
    .typeInterleave(typeInterleave),
    .ctl           (ctl),
    .busyReject    (busyReject),
    .modeErr       (modeErr)
  );

  bcg_datapath #(.EARLY_SLOTS(EARLY_SLOTS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .colIdx    (colIdx),
    .dataValid (dataValid),
    .driveEn   (driveEn),
    .wrRecStart(wrRecStart)
  );

  assign beatValid = ctl.active;
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  localparam int CYC = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cmdValid, cmdWrite, cmdChopN, typeInterleave;
  logic [2:0] startCol;
  logic [1:0] modeBurstLen;
  logic       beatValid, dataValid, driveEn, wrRecStart, busyReject, modeErr;
  logic [2:0] colIdx;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #(CYC/2) clk = ~clk;

  burst_col_gen u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdChopN(cmdChopN), .startCol(startCol), .modeBurstLen(modeBurstLen),
    .typeInterleave(typeInterleave), .beatValid(beatValid), .colIdx(colIdx),
    .dataValid(dataValid), .driveEn(driveEn), .wrRecStart(wrRecStart),
    .busyReject(busyReject), .modeErr(modeErr)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] expCol(input logic [2:0] ca, input bit inter,
                                        input bit wr, input bit chop, input int i);
    logic [2:0] b = 3'(i);
    if (chop && i >= 4) return 3'd0;
    if (wr) return chop ? {ca[2], b[1:0]} : b;
    if (inter) return ca ^ b;
    return {ca[2] ^ b[2], 2'(ca[1:0] + b[1:0])};
  endfunction

  // packed observation: beatValid, colIdx, dataValid, driveEn, wrRecStart, modeErr
  function automatic logic [15:0] obs();
    return {8'd0, beatValid, colIdx, dataValid, driveEn, wrRecStart, modeErr};
  endfunction

  task automatic checkIdle(input string tag);
    check(tag, obs(), 16'd0);
  endtask

  // called at a negedge; returns at the negedge of beat 7
  task automatic burst(input logic [1:0] mode, input bit inter, input bit wr,
                       input bit chopN, input logic [2:0] ca,
                       input bit pokeBusy, input bit scramble);
    bit chop  = (mode == 2'b10) || (mode == 2'b01 && !chopN);
    bit fixed = (mode == 2'b10);
    bit err   = (mode == 2'b11);
    string tag;
    cmdValid = 1; cmdWrite = wr; cmdChopN = chopN; startCol = ca;
    modeBurstLen = mode; typeInterleave = inter;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cmdValid = 0;
      if (scramble) begin   // R12: disturb sampled inputs mid-burst
        modeBurstLen = 2'($urandom); typeInterleave = 1'($urandom);
        cmdChopN = 1'($urandom); startCol = 3'($urandom); cmdWrite = 1'($urandom);
      end
      if (wr) tag = chop ? "R5 chopped write" : "R6 full write";
      else if (chop) tag = "R4 chopped read";
      else tag = inter ? "R3 interleaved read" : "R2 sequential read";
      if (mode == 2'b11) tag = {tag, " R8 reserved"};
      if (mode == 2'b01) tag = {tag, " R7 on-the-fly"};
      if (scramble) tag = {tag, " R12"};
      check($sformatf("%s R10 R9 beat %0d", tag, i), obs(),
            {8'd0, 1'b1, expCol(ca, inter, wr, chop, i),
             !(chop && i >= 4), !wr && !(chop && i >= 4),
             wr && (i == (fixed ? 5 : 7)), err});
      if (pokeBusy && i == 3) begin
        cmdValid = 1; cmdWrite = !wr; startCol = ~ca;
        #1 check("R11 busyReject mid-burst", {15'd0, busyReject}, 16'd1);
      end
      if (i == 7) check("R11 no reject at last beat", {15'd0, busyReject}, 16'd0);
    end
  endtask

  initial begin
    #(CYC * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 0; cmdValid = 0; cmdWrite = 0; cmdChopN = 1; startCol = 0;
    modeBurstLen = 0; typeInterleave = 0;
    repeat (3) @(negedge clk);
    checkIdle("R1 reset outputs");
    rstN = 1;
    @(negedge clk);
    checkIdle("R1 idle after reset");

    // directed corners
    burst(2'b00, 0, 0, 1, 3'd5, 0, 0);  // R2 start 5
    burst(2'b00, 1, 0, 1, 3'd6, 0, 0);  // R3 start 6, back to back R10
    burst(2'b10, 0, 0, 1, 3'd3, 0, 0);  // R4
    burst(2'b10, 1, 1, 1, 3'd7, 0, 0);  // R5 + R9 early
    burst(2'b01, 0, 1, 0, 3'd6, 0, 0);  // R7 + R9 on-the-fly not early
    burst(2'b01, 1, 1, 1, 3'd3, 0, 0);  // R7 A12=1 -> eight
    burst(2'b11, 0, 1, 0, 3'd2, 0, 0);  // R8
    burst(2'b00, 1, 1, 1, 3'd5, 1, 1);  // R6 + R11 + R12
    @(negedge clk);
    cmdValid = 0;
    checkIdle("R1 idle after last beat");

    for (int n = 0; n < 300; n++) begin
      burst(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom),
            ($urandom % 4) == 0, ($urandom % 3) == 0);
      if (($urandom % 3) == 0) begin
        cmdValid = 0;
        @(negedge clk);
        checkIdle("R1 idle gap");
      end
    end
    cmdValid = 0;
    @(negedge clk);
    checkIdle("R1 idle at end");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule